// File: doc/BRIEF.md
# Arbitrated Burst Memory Bus

A small shared bus through which several requesters move bursts of bytes to and from a single byte-addressed memory. A requester presents a start address, a word count and a direction, then asks for the bus. Asking is possible in two ways. A blocking request is held high until the grant arrives. A try is a one-cycle probe that reports success or failure in the same cycle and never waits.

Once granted, a requester owns the bus for the whole burst. The burst begins with a fixed access overhead. Each word then costs a fixed wait followed by one transfer cycle. Read words leave in ascending address order with a valid strobe. Write words enter through a ready/valid handshake, so a slow writer stretches the burst. A one-cycle done pulse marks the release of the bus. A waiting requester can own the bus from the next cycle. When requests collide, they are served round-robin, starting after the most recent owner.

Top module: `arb_burst_bus`

## Requirements
- R1: After reset, no grant is asserted and done, rd_valid and wr_ready are all low.
- R2: When the bus is free, a blocking request is granted in the next cycle. The grant is one-hot and stays on the same requester for the whole burst.
- R3: Among requesters asking in the same free cycle, the grant goes to the first one after the most recent owner in increasing index order, wrapping at NREQ. Requester 0 is first after reset.
- R4: A try pulse gets try_ok in the same cycle if it wins arbitration on a free bus, and the grant follows in the next cycle. It gets try_fail instead if the bus is owned or another requester wins. A failed try causes no grant.
- R5: A read burst of L>0 words keeps the grant for OVH + L*(PW+1) cycles. Its first rd_valid comes OVH+PW cycles after the grant rises, and later words follow every PW+1 cycles.
- R6: Read words come out in increasing address order, one byte per word. The address wraps modulo the memory size (64 bytes by default).
- R7: A write word is stored when wr_valid and wr_ready are both high. Each cycle that wr_ready waits for wr_valid adds one cycle to the burst.
- R8: Done is high for exactly one cycle, the first cycle with no grant after a burst. A pending request may be granted in the following cycle.
- R9: A burst of length 0 moves no words and holds the grant for exactly OVH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NREQ | Blocking ownership request, one per requester |
| try_req | input | NREQ | One-cycle non-blocking ownership probe |
| cmd_addr | input | NREQ*AW | Start byte address per requester |
| cmd_len | input | NREQ*LW | Word count per requester |
| cmd_wr | input | NREQ | Direction per requester, 1 = write |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 8 | Write word |
| grant | output | NREQ | One-hot current owner |
| try_ok | output | NREQ | Try succeeded (same cycle) |
| try_fail | output | NREQ | Try refused (same cycle) |
| rd_valid | output | 1 | Read word present |
| rd_data | output | 8 | Read word |
| wr_ready | output | 1 | Write word accepted this cycle if valid |
| done | output | 1 | Ownership released this cycle |

## Verification
A table of single-requester bursts first writes three regions, one of which crosses the top address, and then reads them back. The read-back shows whether address order and wrap are right, and whether the burst length matches the cycle formula. Three simultaneous zero-length requests show whether rotation starts after the last owner and whether the done-to-grant gap is one cycle. Tries against an owned bus, against a free bus, and against a competing blocking request separate the refusal path from the success path. A write with a withheld valid shows whether stalls lengthen the burst by exactly the stalled cycles and leave the stored data intact.

// File: rtl/arb_burst_bus.sv
module arb_burst_bus #(
  parameter int NREQ = 3,
  parameter int AW   = 6,
  parameter int LW   = 4,
  parameter int OVH  = 100,
  parameter int PW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req,
  input  logic [NREQ-1:0]   try_req,
  input  logic [NREQ*AW-1:0] cmd_addr,
  input  logic [NREQ*LW-1:0] cmd_len,
  input  logic [NREQ-1:0]   cmd_wr,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic [NREQ-1:0]   grant,
  output logic [NREQ-1:0]   try_ok,
  output logic [NREQ-1:0]   try_fail,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              wr_ready,
  output logic              done
);
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int CMAX  = (OVH > PW) ? OVH : PW;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_OVH, S_WAIT, S_XFER, S_DONE} st_t;

  st_t           st;
  logic [IW-1:0] owner, last, pick;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [LW-1:0] left;
  logic          dir, found, free, take;
  logic [NREQ-1:0] cand, pick_oh;
  logic [7:0]    mem [DEPTH];

  assign cand = req | try_req;
  assign free = (st == S_IDLE) || (st == S_DONE);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NREQ; k++) begin
      int j;
      j = (int'(last) + k) % NREQ;
      if (!found && cand[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end

  assign take     = free && found;
  assign pick_oh  = take ? (NREQ'(1) << pick) : '0;
  assign try_ok   = try_req & pick_oh;
  assign try_fail = try_req & ~pick_oh;
  assign grant    = free ? '0 : (NREQ'(1) << owner);
  assign rd_valid = (st == S_XFER) && !dir;
  assign wr_ready = (st == S_XFER) && dir;
  assign rd_data  = mem[addr];
  assign done     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      owner <= '0;
      last  <= IW'(NREQ - 1);
      cnt   <= '0;
      addr  <= '0;
      left  <= '0;
      dir   <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (take) begin
            owner <= pick;
            last  <= pick;
            addr  <= cmd_addr[pick*AW +: AW];
            left  <= cmd_len[pick*LW +: LW];
            dir   <= cmd_wr[pick];
            cnt   <= '0;
            st    <= S_OVH;
          end else begin
            st <= S_IDLE;
          end
        end
        S_OVH: begin
          if (cnt == CW'(OVH - 1)) begin
            cnt <= '0;
            st  <= (left == '0) ? S_DONE : S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt == CW'(PW - 1)) begin
            cnt <= '0;
            st  <= S_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_XFER: begin
          if (!dir || wr_valid) begin
            addr <= addr + 1'b1;
            left <= left - 1'b1;
            st   <= (left == LW'(1)) ? S_DONE : S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_XFER && dir && wr_valid)
      mem[addr] <= wr_data;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && (|$past(grant))) |-> (grant == $past(grant)));

  // R4
  try_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|try_ok) |=> (grant == $past(try_ok)));

  // R8
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|grant) |-> done);

  // R5
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R7
  xfer_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready) |-> (|grant));
endmodule

// File: tb/sim_arb_burst_bus.sv
`timescale 1ns/1ps
module sim_arb_burst_bus;
  localparam int N = 3, AW = 6, LW = 4, OVH = 100, PW = 10;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0, try_req = '0, cmd_wr = '0;
  logic [N*AW-1:0] cmd_addr = '0;
  logic [N*LW-1:0] cmd_len = '0;
  logic wr_valid = 0;
  logic [7:0] wr_data = '0;
  logic [N-1:0] grant, try_ok, try_fail;
  logic rd_valid, wr_ready, done;
  logic [7:0] rd_data;

  arb_burst_bus #(.NREQ(N), .AW(AW), .LW(LW), .OVH(OVH), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .try_req(try_req),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wr(cmd_wr),
    .wr_valid(wr_valid), .wr_data(wr_data), .grant(grant),
    .try_ok(try_ok), .try_fail(try_fail), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_ready(wr_ready), .done(done));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] shadow [64];
  bit finished = 0;

  // id[20:19] wr[18] addr[17:12] len[11:8] seed[7:0]
  localparam logic [20:0] TBL [9] = '{
    {2'd0, 1'b1, 6'd0,  4'd8,  8'h10},
    {2'd1, 1'b1, 6'd8,  4'd8,  8'h40},
    {2'd2, 1'b1, 6'd60, 4'd6,  8'hA0},
    {2'd0, 1'b0, 6'd0,  4'd8,  8'h00},
    {2'd1, 1'b0, 6'd60, 4'd6,  8'h00},
    {2'd2, 1'b0, 6'd8,  4'd5,  8'h00},
    {2'd1, 1'b1, 6'd20, 4'd15, 8'h77},
    {2'd2, 1'b0, 6'd20, 4'd15, 8'h00},
    {2'd0, 1'b0, 6'd2,  4'd10, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cmd(input int id, input bit wr, input int addr, input int len);
    cmd_wr[id] = wr;
    cmd_addr[id*AW +: AW] = AW'(addr);
    cmd_len[id*LW +: LW] = LW'(len);
  endtask

  task automatic run_burst(input int id, input bit wr, input int addr, input int len,
                           input logic [7:0] seed, input int stall);
    int cyc, k, first, sl;
    @(negedge clk);
    set_cmd(id, wr, addr, len);
    req[id] = 1;
    @(negedge clk);
    chk(grant == (N'(1) << id), "R2 grant next cycle", int'(grant), 1 << id);
    req[id] = 0;
    cyc = 0; k = 0; first = -1; sl = stall;
    while (grant[id] && cyc < 3000) begin
      if (rd_valid) begin
        chk(rd_data == shadow[(addr + k) % 64], "R6 read data", int'(rd_data),
            int'(shadow[(addr + k) % 64]));
        if (k == 0) first = cyc;
        k++;
      end
      if (wr_ready) begin
        if (sl > 0) begin
          wr_valid = 0; sl--;
        end else begin
          wr_valid = 1; wr_data = seed + 8'(k);
          shadow[(addr + k) % 64] = seed + 8'(k);
          k++;
        end
      end else wr_valid = 0;
      cyc++;
      @(negedge clk);
    end
    wr_valid = 0;
    chk(done == 1'b1, "R8 done at release", int'(done), 1);
    chk(cyc == OVH + len * (PW + 1) + stall, wr ? "R7 write duration" : "R5 read duration",
        cyc, OVH + len * (PW + 1) + stall);
    chk(k == len, "R6 word count", k, len);
    if (!wr && len > 0) chk(first == OVH + PW, "R5 first word", first, OVH + PW);
  endtask

  task automatic hold_owner(input int id, output int cyc, output int rv);
    cyc = 0; rv = 0;
    while (grant[id] && cyc < 3000) begin
      if (rd_valid) rv++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc, rv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(grant == '0, "R1 grant after reset", int'(grant), 0);
    chk(!done && !rd_valid && !wr_ready, "R1 strobes after reset",
        int'({done, rd_valid, wr_ready}), 0);

    for (int i = 0; i < 9; i++)
      run_burst(int'(TBL[i][20:19]), TBL[i][18], int'(TBL[i][17:12]),
                int'(TBL[i][11:8]), TBL[i][7:0], 0);

    // R3 R8 R9: last owner is 0, so order is 1, 2, 0
    @(negedge clk);
    for (int i = 0; i < N; i++) set_cmd(i, 0, 0, 0);
    req = '1;
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      int id;
      id = (s + 1) % N;
      chk(grant == (N'(1) << id), "R3 rotation order", int'(grant), 1 << id);
      req[id] = 0;
      hold_owner(id, cyc, rv);
      chk(cyc == OVH, "R9 zero-length duration", cyc, OVH);
      chk(rv == 0, "R9 no words moved", rv, 0);
      chk(done && grant == '0, "R8 done cycle without grant", int'({done, grant}), 8);
      @(negedge clk);
    end
    chk(done == 0, "R8 done single cycle", int'(done), 0);

    // R4: refused while owned
    set_cmd(0, 0, 0, 0);
    req[0] = 1;
    @(negedge clk);
    req[0] = 0;
    repeat (5) @(negedge clk);
    set_cmd(1, 0, 0, 0);
    try_req[1] = 1;
    #1;
    chk(try_fail[1] && try_ok == '0, "R4 try refused when owned", int'({try_ok, try_fail}), 2);
    @(negedge clk);
    try_req[1] = 0;
    chk(grant == 3'b001, "R4 owner unchanged after refused try", int'(grant), 1);
    hold_owner(0, cyc, rv);
    @(negedge clk);
    @(negedge clk);
    chk(grant == '0, "R4 refused try gives no grant", int'(grant), 0);

    // R4: success on free bus
    set_cmd(2, 0, 0, 0);
    try_req[2] = 1;
    #1;
    chk(try_ok == 3'b100 && try_fail == '0, "R4 try accepted when free",
        int'({try_ok, try_fail}), 32);
    @(negedge clk);
    try_req[2] = 0;
    chk(grant == 3'b100, "R4 grant after try", int'(grant), 4);
    hold_owner(2, cyc, rv);
    @(negedge clk);

    // R4 R3: try loses to blocking request after owner 2
    set_cmd(0, 0, 0, 0); set_cmd(1, 0, 0, 0);
    req[0] = 1; try_req[1] = 1;
    #1;
    chk(try_fail[1] && try_ok == '0, "R4 try loses arbitration", int'({try_ok, try_fail}), 2);
    @(negedge clk);
    req[0] = 0; try_req[1] = 0;
    chk(grant == 3'b001, "R3 rotation after owner 2", int'(grant), 1);
    hold_owner(0, cyc, rv);
    @(negedge clk);

    // R7: stalled write then read back
    run_burst(1, 1, 30, 3, 8'h55, 4);
    run_burst(0, 0, 30, 3, 8'h00, 0);
    run_burst(2, 0, 62, 4, 8'h00, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule